// File: doc/BRIEF.md
# Integrity-Gated Commit and Fetch Stall Unit

This pipeline control block sits at the commit point of a small in-order core that runs code and data out of encrypted, authenticated external memory. Cache fills arrive before their integrity check ends, so each fill carries a verification tag that stays outstanding until the integrity engine reports a pass or a fail for it. The block tracks which tags are outstanding, which architectural registers hold values derived from them, and whether the current control path was steered by such a value. It holds back only the operations that could change state, or reveal secrets through their addresses, on the strength of content that is not yet verified.

Gating is per item and not per region. Each register keeps a set of the tags it depends on, and is treated as tainted while any tag in that set is outstanding. An operation with no outstanding dependency commits in the cycle it is presented. A branch that resolves on tainted inputs never stalls itself. Instead it raises a control-taint set that holds the front end's fetch until all of those tags pass. A failed check latches a fault that squashes every later operation and freezes fetch until reset.

Top module: `igate_unit`

## Requirements
- R1: A fill with `fill_valid_i` high makes `fill_tag_i` outstanding from the next cycle. A pass result (`vrfy_ok_i` high) for an outstanding tag retires it from the next cycle. If a fill and a verification name the same tag in one cycle, the fill wins.
- R2: An operation whose own tag (`ins_tag_valid_i`, `ins_tag_i`) is outstanding is stalled when it is an ALU op (1), load (2) or store (3). It commits in the cycle after that tag passes.
- R3: An ALU op (1) with a tainted `src_a_i` or `src_b_i`, or a store (3) whose data register `src_b_i` is tainted, is stalled. A register is tainted while any tag in its dependency set is outstanding.
- R4: A load (2) or store (3) whose address register `src_a_i` is tainted is stalled.
- R5: A committed load sets its destination's dependency set to `ld_tag_i` when `ld_tag_valid_i` is high, and to empty otherwise. A committed ALU op empties its destination's set. A pass on a tag removes that tag from every set in the same update.
- R6: A branch (4) never stalls. When it commits, its own outstanding tag and the outstanding tags of both source registers join the control-taint set. `fetch_stall_o` is high from the next cycle while any tag in that set is outstanding.
- R7: An operation with no outstanding dependency, and any NOP (0, or the unused codes 5 to 7), gives `commit_o` high and `commit_stall_o` low in the same cycle, with no added stall.
- R8: A fail result (`vrfy_ok_i` low) for an outstanding tag raises `fault_o` from the next cycle. The fault holds until reset. While it is set, every valid operation is stalled and not committed, and `fetch_stall_o` is high.
- R9: A verification result, pass or fail, for a tag that is not outstanding has no effect.
- R10: After reset no tag is outstanding, no register or control path is tainted, and `commit_stall_o`, `fetch_stall_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | A fill with a pending integrity check arrived |
| fill_tag_i | input | TAG_W | Verification tag of that fill |
| vrfy_valid_i | input | 1 | Integrity engine reports a result |
| vrfy_tag_i | input | TAG_W | Tag the result belongs to |
| vrfy_ok_i | input | 1 | 1 = check passed, 0 = check failed |
| ins_valid_i | input | 1 | An operation is presented at commit |
| ins_op_i | input | 3 | 0 NOP, 1 ALU, 2 load, 3 store, 4 branch |
| ins_tag_valid_i | input | 1 | The operation's own fetch tag is meaningful |
| ins_tag_i | input | TAG_W | Tag of the line the operation was fetched from |
| src_a_i | input | REG_W | First source (address register for load and store) |
| src_b_i | input | REG_W | Second source (store data) |
| dst_i | input | REG_W | Destination register of ALU op or load |
| ld_tag_valid_i | input | 1 | Load data comes from a line with a tag |
| ld_tag_i | input | TAG_W | Tag of the load data's line |
| commit_o | output | 1 | The presented operation commits this cycle |
| commit_stall_o | output | 1 | The presented operation is held |
| fetch_stall_o | output | 1 | Front-end fetch must wait |
| fault_o | output | 1 | An integrity failure was seen; squash state |

## Verification
The bench sets operation classes against taint that arrives by each route: the operation's own fetch tag, tainted address registers, tainted data registers, and branches on tainted operands. Each route gates a different output or a different class of operation. Sequences where a pass lands while the stalled operation is still held show that release comes exactly one cycle after the result. A load whose data tag passes in the same cycle it commits shows that the clear wins over the new taint. A long random stretch with reused tags tests per-item gating against a stall-free baseline. Results for tags that are not outstanding, and a final fail, separate an ignored report from the sticky squash.

// File: rtl/igate_pkg.sv
package igate_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALU    = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_BRANCH = 3'd4
  } op_e;
endpackage

// File: rtl/igate_tag_table.sv
module igate_tag_table #(
  parameter int NUM_TAGS = 8,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fill_en_i,
  input  logic [TAG_W-1:0]    fill_tag_i,
  input  logic [NUM_TAGS-1:0] clr_i,
  input  logic                flush_i,
  output logic [NUM_TAGS-1:0] pend_o
);
  localparam logic [NUM_TAGS-1:0] ONE = 1;

  logic [NUM_TAGS-1:0] pend_q;
  logic [NUM_TAGS-1:0] set_mask;

  assign set_mask = fill_en_i ? (ONE << fill_tag_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (flush_i) pend_q <= '0;
    else              pend_q <= (pend_q & ~clr_i) | set_mask;  // fill wins
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/igate_taint_file.sv
module igate_taint_file #(
  parameter int NUM_TAGS = 8,
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_addr_i,
  input  logic [NUM_TAGS-1:0] wr_mask_i,
  input  logic [NUM_TAGS-1:0] clr_i,
  input  logic [REG_W-1:0]    rd_a_i,
  input  logic [REG_W-1:0]    rd_b_i,
  output logic [NUM_TAGS-1:0] mask_a_o,
  output logic [NUM_TAGS-1:0] mask_b_o
);
  logic [NUM_REGS-1:0][NUM_TAGS-1:0] dep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dep_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (wr_en_i && (wr_addr_i == REG_W'(r))) dep_q[r] <= wr_mask_i & ~clr_i;
        else                                     dep_q[r] <= dep_q[r] & ~clr_i;
      end
    end
  end

  assign mask_a_o = dep_q[rd_a_i];
  assign mask_b_o = dep_q[rd_b_i];
endmodule

// File: rtl/igate_hazard.sv
module igate_hazard
  import igate_pkg::*;
#(
  parameter int NUM_TAGS = 8
) (
  input  logic                ins_valid_i,
  input  logic [2:0]          op_i,
  input  logic                fault_i,
  input  logic [NUM_TAGS-1:0] own_i,   // outstanding-filtered
  input  logic [NUM_TAGS-1:0] dep_a_i,
  input  logic [NUM_TAGS-1:0] dep_b_i,
  output logic                stall_o,
  output logic                commit_o,
  output logic [NUM_TAGS-1:0] br_dep_o
);
  op_e op;
  logic need_wait;
  logic is_br;

  assign op = op_e'(op_i);

  always_comb begin
    need_wait = 1'b0;
    is_br     = 1'b0;
    case (op)
      OP_ALU, OP_STORE: need_wait = |(own_i | dep_a_i | dep_b_i);
      OP_LOAD:          need_wait = |(own_i | dep_a_i);
      OP_BRANCH:        is_br     = 1'b1;
      default:          need_wait = 1'b0;
    endcase
  end

  assign stall_o  = ins_valid_i & (fault_i | need_wait);
  assign commit_o = ins_valid_i & ~stall_o;
  assign br_dep_o = (commit_o && is_br) ? (own_i | dep_a_i | dep_b_i) : '0;
endmodule

// File: rtl/igate_unit.sv
module igate_unit
  import igate_pkg::*;
#(
  parameter int NUM_TAGS = 8,
  parameter int NUM_REGS = 16,
  localparam int TAG_W = $clog2(NUM_TAGS),
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_valid_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             vrfy_valid_i,
  input  logic [TAG_W-1:0] vrfy_tag_i,
  input  logic             vrfy_ok_i,
  input  logic             ins_valid_i,
  input  logic [2:0]       ins_op_i,
  input  logic             ins_tag_valid_i,
  input  logic [TAG_W-1:0] ins_tag_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             ld_tag_valid_i,
  input  logic [TAG_W-1:0] ld_tag_i,
  output logic             commit_o,
  output logic             commit_stall_o,
  output logic             fetch_stall_o,
  output logic             fault_o
);
  localparam logic [NUM_TAGS-1:0] ONE = 1;

  logic [NUM_TAGS-1:0] pend;
  logic [NUM_TAGS-1:0] vrfy_clr;
  logic [NUM_TAGS-1:0] mask_a, mask_b, own_dep, br_dep, wr_mask;
  logic [NUM_TAGS-1:0] ctl_q;
  logic                vrfy_hit, vrfy_fail, fault_q, wr_en, commit;

  // verification results only count for outstanding tags
  assign vrfy_hit  = vrfy_valid_i & pend[vrfy_tag_i] & ~fault_q;
  assign vrfy_clr  = (vrfy_hit & vrfy_ok_i) ? (ONE << vrfy_tag_i) : '0;
  assign vrfy_fail = vrfy_hit & ~vrfy_ok_i;

  igate_tag_table #(.NUM_TAGS(NUM_TAGS)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_en_i  (fill_valid_i & ~fault_q),
    .fill_tag_i (fill_tag_i),
    .clr_i      (vrfy_clr),
    .flush_i    (vrfy_fail),
    .pend_o     (pend)
  );

  assign wr_en   = commit & ((ins_op_i == OP_ALU) | (ins_op_i == OP_LOAD));
  assign wr_mask = (ins_op_i == OP_LOAD && ld_tag_valid_i) ? (ONE << ld_tag_i) : '0;

  igate_taint_file #(.NUM_TAGS(NUM_TAGS), .NUM_REGS(NUM_REGS)) u_taint (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (dst_i),
    .wr_mask_i (wr_mask),
    .clr_i     (vrfy_clr),
    .rd_a_i    (src_a_i),
    .rd_b_i    (src_b_i),
    .mask_a_o  (mask_a),
    .mask_b_o  (mask_b)
  );

  assign own_dep = ins_tag_valid_i ? ((ONE << ins_tag_i) & pend) : '0;

  igate_hazard #(.NUM_TAGS(NUM_TAGS)) u_hz (
    .ins_valid_i (ins_valid_i),
    .op_i        (ins_op_i),
    .fault_i     (fault_q),
    .own_i       (own_dep),
    .dep_a_i     (mask_a & pend),
    .dep_b_i     (mask_b & pend),
    .stall_o     (commit_stall_o),
    .commit_o    (commit),
    .br_dep_o    (br_dep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      fault_q <= 1'b0;
    end else if (!fault_q) begin
      ctl_q <= (ctl_q | br_dep) & ~vrfy_clr;
      if (vrfy_fail) fault_q <= 1'b1;
    end
  end

  assign commit_o      = commit;
  assign fetch_stall_o = fault_q | (|(ctl_q & pend));
  assign fault_o       = fault_q;
endmodule

// File: rtl/igate_unit_chk.sv
module igate_unit_chk #(
  parameter int NUM_TAGS = 8,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fill_valid_i,
  input logic [TAG_W-1:0]    fill_tag_i,
  input logic                vrfy_valid_i,
  input logic [TAG_W-1:0]    vrfy_tag_i,
  input logic                vrfy_ok_i,
  input logic                ins_valid_i,
  input logic [2:0]          ins_op_i,
  input logic                ins_tag_valid_i,
  input logic [TAG_W-1:0]    ins_tag_i,
  input logic [NUM_TAGS-1:0] pend_i,
  input logic                commit_o,
  input logic                commit_stall_o,
  input logic                fetch_stall_o,
  input logic                fault_o
);
  assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  assert_fault_squash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!commit_o && fetch_stall_o));

  assert_own_tag_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !fault_o && ins_tag_valid_i && pend_i[ins_tag_i] &&
     (ins_op_i == 3'd1 || ins_op_i == 3'd2 || ins_op_i == 3'd3)) |-> commit_stall_o);

  assert_branch_no_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_op_i == 3'd4 && !fault_o) |-> commit_o);

  assert_nop_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_op_i == 3'd0 && !fault_o) |-> (commit_o && !commit_stall_o));

  assert_pass_retires_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrfy_valid_i && vrfy_ok_i && !fault_o && pend_i[vrfy_tag_i] &&
     !(fill_valid_i && fill_tag_i == vrfy_tag_i)) |=> !pend_i[$past(vrfy_tag_i)]);

  assert_fill_marks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fault_o && !(vrfy_valid_i && !vrfy_ok_i && pend_i[vrfy_tag_i]))
      |=> pend_i[$past(fill_tag_i)]);
endmodule

bind igate_unit igate_unit_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fill_valid_i    (fill_valid_i),
  .fill_tag_i      (fill_tag_i),
  .vrfy_valid_i    (vrfy_valid_i),
  .vrfy_tag_i      (vrfy_tag_i),
  .vrfy_ok_i       (vrfy_ok_i),
  .ins_valid_i     (ins_valid_i),
  .ins_op_i        (ins_op_i),
  .ins_tag_valid_i (ins_tag_valid_i),
  .ins_tag_i       (ins_tag_i),
  .pend_i          (pend),
  .commit_o        (commit_o),
  .commit_stall_o  (commit_stall_o),
  .fetch_stall_o   (fetch_stall_o),
  .fault_o         (fault_o)
);

// File: tb/igate_unit_test.sv
`timescale 1ns/1ps
module igate_unit_test;
  localparam int NT = 8;
  localparam int NR = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fill_valid_i = 0, vrfy_valid_i = 0, vrfy_ok_i = 0;
  logic [2:0] fill_tag_i = 0, vrfy_tag_i = 0, ins_tag_i = 0, ld_tag_i = 0;
  logic       ins_valid_i = 0, ins_tag_valid_i = 0, ld_tag_valid_i = 0;
  logic [2:0] ins_op_i = 0;
  logic [3:0] src_a_i = 0, src_b_i = 0, dst_i = 0;
  logic       commit_o, commit_stall_o, fetch_stall_o, fault_o;

  always #2 clk = ~clk;

  igate_unit #(.NUM_TAGS(NT), .NUM_REGS(NR)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fill_valid_i(fill_valid_i), .fill_tag_i(fill_tag_i),
    .vrfy_valid_i(vrfy_valid_i), .vrfy_tag_i(vrfy_tag_i), .vrfy_ok_i(vrfy_ok_i),
    .ins_valid_i(ins_valid_i), .ins_op_i(ins_op_i),
    .ins_tag_valid_i(ins_tag_valid_i), .ins_tag_i(ins_tag_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .ld_tag_valid_i(ld_tag_valid_i), .ld_tag_i(ld_tag_i),
    .commit_o(commit_o), .commit_stall_o(commit_stall_o),
    .fetch_stall_o(fetch_stall_o), .fault_o(fault_o)
  );

  // behavioural reference state
  bit pend_m[NT];
  int dep_m[NR][$];
  int ctl_m[$];
  bit flt_m;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic bit tainted(int r);
    foreach (dep_m[r][i]) if (pend_m[dep_m[r][i]]) return 1;
    return 0;
  endfunction

  function automatic void drop_tag(int t);
    int q[$];
    for (int r = 0; r < NR; r++) begin
      q = {};
      foreach (dep_m[r][i]) if (dep_m[r][i] != t) q.push_back(dep_m[r][i]);
      dep_m[r] = q;
    end
    q = {};
    foreach (ctl_m[i]) if (ctl_m[i] != t) q.push_back(ctl_m[i]);
    ctl_m = q;
  endfunction

  function automatic void model_reset();
    for (int t = 0; t < NT; t++) pend_m[t] = 0;
    for (int r = 0; r < NR; r++) dep_m[r] = {};
    ctl_m = {};
    flt_m = 0;
  endfunction

  task automatic chk(string req, string nm, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // called just after a falling edge with inputs already driven
  task automatic cyc(string req);
    bit own, ta, tb, hz, e_stall, e_commit, e_fs, hit;
    #1;
    own = ins_tag_valid_i && pend_m[ins_tag_i];
    ta = tainted(src_a_i);
    tb = tainted(src_b_i);
    case (ins_op_i)
      3'd1, 3'd3: hz = own | ta | tb;
      3'd2:       hz = own | ta;
      default:    hz = 0;
    endcase
    e_stall  = ins_valid_i && (flt_m || hz);
    e_commit = ins_valid_i && !e_stall;
    e_fs = flt_m;
    foreach (ctl_m[i]) if (pend_m[ctl_m[i]]) e_fs = 1;
    chk(req, "commit_o", commit_o, e_commit);
    chk(req, "commit_stall_o", commit_stall_o, e_stall);
    chk(req, "fetch_stall_o", fetch_stall_o, e_fs);
    chk(req, "fault_o", fault_o, flt_m);
    @(posedge clk);
    if (!flt_m) begin
      hit = vrfy_valid_i && pend_m[vrfy_tag_i];
      if (e_commit) begin
        if (ins_op_i == 3'd1) dep_m[dst_i] = {};
        else if (ins_op_i == 3'd2) begin
          dep_m[dst_i] = {};
          if (ld_tag_valid_i) dep_m[dst_i].push_back(int'(ld_tag_i));
        end else if (ins_op_i == 3'd4) begin
          if (own) ctl_m.push_back(int'(ins_tag_i));
          foreach (dep_m[src_a_i][i]) if (pend_m[dep_m[src_a_i][i]]) ctl_m.push_back(dep_m[src_a_i][i]);
          foreach (dep_m[src_b_i][i]) if (pend_m[dep_m[src_b_i][i]]) ctl_m.push_back(dep_m[src_b_i][i]);
        end
      end
      if (hit && vrfy_ok_i) begin
        drop_tag(vrfy_tag_i);
        pend_m[vrfy_tag_i] = 0;
      end
      if (hit && !vrfy_ok_i) begin
        flt_m = 1;
        for (int t = 0; t < NT; t++) pend_m[t] = 0;
      end else if (fill_valid_i) pend_m[fill_tag_i] = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    fill_valid_i = 0; vrfy_valid_i = 0; ins_valid_i = 0;
    ins_tag_valid_i = 0; ld_tag_valid_i = 0; ins_op_i = 0;
  endtask

  task automatic op(logic [2:0] o, logic tv, int t, int a, int b, int d, logic lv, int lt);
    ins_valid_i = 1; ins_op_i = o; ins_tag_valid_i = tv; ins_tag_i = 3'(t);
    src_a_i = 4'(a); src_b_i = 4'(b); dst_i = 4'(d); ld_tag_valid_i = lv; ld_tag_i = 3'(lt);
  endtask

  task automatic fill(int t);
    fill_valid_i = 1; fill_tag_i = 3'(t);
  endtask

  task automatic vrfy(int t, logic ok);
    vrfy_valid_i = 1; vrfy_tag_i = 3'(t); vrfy_ok_i = ok;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    idle();
    model_reset();
    @(negedge clk);
    chk("R10", "commit_stall_o", commit_stall_o, 1'b0);
    chk("R10", "fetch_stall_o", fetch_stall_o, 1'b0);
    chk("R10", "fault_o", fault_o, 1'b0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    cyc("R10");

    // R1 / R2: own tag outstanding holds an ALU op until the pass lands
    idle(); fill(2); cyc("R1");
    idle(); op(3'd1, 1, 2, 0, 1, 3, 0, 0); cyc("R2");
    vrfy(2, 1); cyc("R2");
    idle(); op(3'd1, 1, 2, 0, 1, 3, 0, 0); cyc("R2");
    // fill and pass on the same tag: fill wins
    idle(); fill(6); cyc("R1");
    idle(); fill(6); vrfy(6, 1); cyc("R1");
    idle(); op(3'd3, 1, 6, 0, 1, 0, 0, 0); cyc("R1");
    idle(); vrfy(6, 1); cyc("R1");

    // R5 / R3 / R4: load taints its destination
    idle(); fill(3); cyc("R5");
    idle(); op(3'd2, 0, 0, 1, 0, 4, 1, 3); cyc("R5");
    idle(); op(3'd1, 0, 0, 2, 4, 5, 0, 0); cyc("R3");
    idle(); op(3'd3, 0, 0, 0, 4, 0, 0, 0); cyc("R3");
    idle(); op(3'd3, 0, 0, 4, 0, 0, 0, 0); cyc("R4");
    idle(); op(3'd2, 0, 0, 4, 0, 7, 0, 0); cyc("R4");
    vrfy(3, 1); cyc("R5");
    idle(); op(3'd1, 0, 0, 2, 4, 5, 0, 0); cyc("R5");
    // load commits while its data tag passes in the same cycle
    idle(); fill(5); cyc("R5");
    idle(); op(3'd2, 0, 0, 1, 0, 6, 1, 5); vrfy(5, 1); cyc("R5");
    idle(); op(3'd2, 0, 0, 6, 0, 8, 0, 0); cyc("R4");

    // R6: branch on tainted register gates fetch
    idle(); fill(1); cyc("R6");
    idle(); op(3'd2, 0, 0, 1, 0, 9, 1, 1); cyc("R6");
    idle(); op(3'd4, 0, 0, 9, 2, 0, 0, 0); cyc("R6");
    idle(); cyc("R6");
    idle(); cyc("R6");
    vrfy(1, 1); cyc("R6");
    idle(); cyc("R6");
    // branch fetched from an unverified line
    idle(); fill(4); cyc("R6");
    idle(); op(3'd4, 1, 4, 0, 0, 0, 0, 0); cyc("R6");
    idle(); cyc("R6");
    vrfy(4, 1); cyc("R6");
    idle(); cyc("R6");

    // R9: results for tags not outstanding are ignored
    idle(); vrfy(7, 0); cyc("R9");
    idle(); op(3'd1, 0, 0, 1, 2, 3, 0, 0); cyc("R9");
    idle(); vrfy(0, 1); cyc("R9");
    idle(); cyc("R9");

    // R7: clean operations, every class
    for (int k = 0; k < 5; k++) begin
      idle(); op(3'(k), 0, 0, 10, 11, 12, 0, 0); cyc("R7");
    end

    // random stretch with passes only
    for (int k = 0; k < 1500; k++) begin
      idle();
      if ($urandom_range(0, 2) == 0) fill($urandom_range(0, NT-1));
      if ($urandom_range(0, 3) == 0) vrfy($urandom_range(0, NT-1), 1);
      if ($urandom_range(0, 3) != 0)
        op(3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), $urandom_range(0, NT-1),
           $urandom_range(0, NR-1), $urandom_range(0, NR-1), $urandom_range(0, NR-1),
           1'($urandom_range(0, 1)), $urandom_range(0, NT-1));
      cyc("R7");
    end

    // R8: a fail on an outstanding tag squashes until reset
    do_reset();
    idle(); fill(1); cyc("R8");
    idle(); op(3'd2, 0, 0, 0, 0, 2, 1, 1); cyc("R8");
    idle(); op(3'd1, 0, 0, 2, 0, 3, 0, 0); vrfy(1, 0); cyc("R8");
    idle(); op(3'd1, 0, 0, 2, 0, 3, 0, 0); cyc("R8");
    idle(); op(3'd0, 0, 0, 0, 0, 0, 0, 0); fill(3); cyc("R8");
    idle(); op(3'd4, 0, 0, 0, 0, 0, 0, 0); vrfy(3, 1); cyc("R8");
    idle(); cyc("R8");
    do_reset();
    idle(); op(3'd1, 0, 0, 2, 0, 3, 0, 0); cyc("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule